// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one character per handshake into an asynchronous serial frame on a single output line that sits high when nothing is being sent. Every frame opens with a low start bit. The data bits follow, lowest bit first, and there are five to nine of them. An even or odd parity bit may come next. The frame closes with one or two high stop bits. Three static configuration inputs pick the character length, the parity mode and the stop-bit count, so all thirty formats can be chosen at run time.

The pace comes from an external single-cycle strobe, `bit_tick`, with one strobe per bit period. Characters enter over a valid/ready stream port that is nine bits wide. The producer raises `in_valid` with the data and holds both steady until a cycle in which `in_ready` is also high. The transfer happens at that clock edge. `in_ready` is only ever high in a cycle where `bit_tick` is high and the transmitter is either idle or sending its final stop bit. This means a producer with a character ready can start the next frame directly after the last stop bit, with no idle gap. A producer that holds `in_valid` while the line is busy is simply made to wait. `busy` is high for as long as a frame is on the line.

Top module: `cfg_frame_tx`

## Requirements
- R1: `in_ready` is high only in a cycle where `bit_tick` is high and the block is either idle or sending the final stop bit. A character is taken at a rising edge where `in_valid` and `in_ready` are both high.
- R2: In the cycle after a character is taken, `busy` is high and `tx_line` is low, which is the start bit. `busy` stays high until the last stop bit ends.
- R3: Data bits go out lowest bit first. The number sent is set by `cfg_size`: 000 gives 5, 001 gives 6, 010 gives 7, 011 gives 8 and 111 gives 9. The codes 100, 101 and 110 give 8. Bits of `in_data` above the selected length are never sent.
- R4: `cfg_par` selects the parity mode: 10 is even, 11 is odd, and 00 or 01 is none. When parity is on, one parity bit follows the last data bit. With even parity the number of ones across the data bits and the parity bit is even. With odd parity that number is odd.
- R5: One high stop bit closes the frame when `cfg_stop2` is 0, and two high stop bits when it is 1.
- R6: `tx_line` changes only at a rising edge where `bit_tick` is high. Each bit of the frame therefore lasts exactly one tick period.
- R7: After reset, and whenever no frame is active, `tx_line` is high and `busy` is low.
- R8: The format is captured when a character is taken. Changing `cfg_size`, `cfg_par` or `cfg_stop2` during a frame does not change that frame.
- R9: If `in_valid` is high during the final stop bit, the next start bit begins at the tick that ends that stop bit, with no idle cycle between the frames.
- R10: While `in_ready` is low, `in_valid` and `in_data` have no effect. The character sent is the one present at the transfer edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe, one per bit period |
| cfg_size | input | 3 | Character length code |
| cfg_par | input | 2 | Parity mode code |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Character can be taken at this edge |
| in_data | input | 9 | Character, bit 0 sent first |
| tx_line | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in progress |

## Verification
The bench builds the block with its default package parameters: a nine-bit data word and a thirteen-position frame register. The longest frame, with nine data bits, parity and two stop bits, fills that register completely. The bench steps through every size and parity code, including the codes that fall back to a default, and both stop-bit choices. It varies the tick period from one cycle to four, so it covers the case where a tick arrives on every clock. It also sends back-to-back frames, changes the configuration in the middle of a frame, and holds `in_valid` high while the block is busy.

// File: rtl/cfg_frame_pkg.sv
package cfg_frame_pkg;

  localparam int unsigned DATA_MAX  = 9;
  localparam int unsigned FRAME_MAX = DATA_MAX + 4;
  localparam int unsigned CNT_W     = $clog2(FRAME_MAX + 1);

  localparam logic [2:0] SZ_5 = 3'b000;
  localparam logic [2:0] SZ_6 = 3'b001;
  localparam logic [2:0] SZ_7 = 3'b010;
  localparam logic [2:0] SZ_8 = 3'b011;
  localparam logic [2:0] SZ_9 = 3'b111;

  typedef struct packed {
    logic [CNT_W-1:0] nbits;
    logic             par_en;
    logic             par_odd;
    logic [CNT_W-1:0] len;
  } fmt_t;

endpackage

// File: rtl/frame_fmt_decode.sv
module frame_fmt_decode
  import cfg_frame_pkg::*;
(
  input  logic [2:0] size_code,
  input  logic [1:0] par_code,
  input  logic       stop2,
  output fmt_t       fmt
);

  logic [CNT_W-1:0] nb;

  always_comb begin
    unique case (size_code)
      SZ_5:    nb = CNT_W'(5);
      SZ_6:    nb = CNT_W'(6);
      SZ_7:    nb = CNT_W'(7);
      SZ_8:    nb = CNT_W'(8);
      SZ_9:    nb = CNT_W'(9);
      default: nb = CNT_W'(8);
    endcase
  end

  always_comb begin
    fmt.nbits   = nb;
    fmt.par_en  = par_code[1];
    fmt.par_odd = par_code[1] & par_code[0];
    fmt.len     = CNT_W'(1) + nb + CNT_W'(par_code[1]) + (stop2 ? CNT_W'(2) : CNT_W'(1));
  end

endmodule

// File: rtl/frame_assemble.sv
module frame_assemble
  import cfg_frame_pkg::*;
(
  input  logic [DATA_MAX-1:0]  data,
  input  fmt_t                 fmt,
  output logic [FRAME_MAX-1:0] frame
);

  logic [DATA_MAX-1:0] masked;
  logic                parity;

  for (genvar i = 0; i < DATA_MAX; i++) begin : g_mask
    assign masked[i] = data[i] & (CNT_W'(i) < fmt.nbits);
  end

  assign parity = (^masked) ^ fmt.par_odd;

  for (genvar k = 0; k < FRAME_MAX; k++) begin : g_bit
    if (k == 0) begin : g_start
      assign frame[k] = 1'b0;
    end else if (k - 1 < DATA_MAX) begin : g_data
      assign frame[k] = (CNT_W'(k - 1) < fmt.nbits) ? data[k-1] :
                        ((CNT_W'(k - 1) == fmt.nbits) && fmt.par_en) ? parity : 1'b1;
    end else begin : g_tail
      assign frame[k] = ((CNT_W'(k - 1) == fmt.nbits) && fmt.par_en) ? parity : 1'b1;
    end
  end

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import cfg_frame_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 offer,
  input  logic [FRAME_MAX-1:0] frame,
  input  logic [CNT_W-1:0]     len,
  output logic                 take_ok,
  output logic                 active,
  output logic                 line
);

  logic [FRAME_MAX-1:0] sreg;
  logic [CNT_W-1:0]     remain;
  logic                 active_q;
  logic                 last_bit;
  logic                 take;

  assign last_bit = active_q && (remain == CNT_W'(1));
  assign take_ok  = tick && (!active_q || last_bit);
  assign take     = take_ok && offer;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg     <= '1;
      remain   <= '0;
      active_q <= 1'b0;
    end else if (take) begin
      sreg     <= frame;
      remain   <= len;
      active_q <= 1'b1;
    end else if (tick && active_q) begin
      sreg   <= {1'b1, sreg[FRAME_MAX-1:1]};
      remain <= remain - CNT_W'(1);
      if (last_bit) active_q <= 1'b0;
    end
  end

  assign active = active_q;
  assign line   = sreg[0];

endmodule

// File: rtl/cfg_frame_tx.sv
module cfg_frame_tx
  import cfg_frame_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_tick,
  input  logic [2:0]          cfg_size,
  input  logic [1:0]          cfg_par,
  input  logic                cfg_stop2,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_MAX-1:0] in_data,
  output logic                tx_line,
  output logic                busy
);

  fmt_t                 fmt;
  logic [FRAME_MAX-1:0] frame;

  frame_fmt_decode i_dec (
    .size_code (cfg_size),
    .par_code  (cfg_par),
    .stop2     (cfg_stop2),
    .fmt       (fmt)
  );

  frame_assemble i_asm (
    .data  (in_data),
    .fmt   (fmt),
    .frame (frame)
  );

  frame_shifter i_shf (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (bit_tick),
    .offer   (in_valid),
    .frame   (frame),
    .len     (fmt.len),
    .take_ok (in_ready),
    .active  (busy),
    .line    (tx_line)
  );

endmodule

// File: rtl/cfg_frame_tx_chk.sv
module cfg_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic in_valid,
  input logic in_ready,
  input logic tx_line,
  input logic busy
);

  // R7
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_line);

  // R1
  ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> bit_tick);

  // R2
  start_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !tx_line));

  // R6
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(tx_line));

  // R5
  stop_before_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tx_line));

  // R1
  final_bit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_ready && !in_valid) |=> !busy);

endmodule

bind cfg_frame_tx cfg_frame_tx_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_tick (bit_tick),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .tx_line  (tx_line),
  .busy     (busy)
);

// File: tb/test_cfg_frame_tx.sv
`timescale 1ns/1ps
module test_cfg_frame_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic [2:0] cfg_size = 3'b011;
  logic [1:0] cfg_par = 2'b00;
  logic       cfg_stop2 = 1'b0;
  logic       in_valid = 1'b0;
  logic [8:0] in_data = '0;
  logic       in_ready;
  logic       tx_line;
  logic       busy;

  always #2.5 clk = ~clk;

  cfg_frame_tx i_cfg_frame_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cfg_size(cfg_size),
    .cfg_par(cfg_par), .cfg_stop2(cfg_stop2), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .tx_line(tx_line), .busy(busy)
  );

  int    checks = 0;
  int    fails = 0;
  int    cycles = 0;
  int    tick_div = 4;
  int    tick_cnt = 0;
  int    accepted = 0;
  bit    exp_line = 1'b1;
  bit    exp_busy = 1'b0;
  bit    prev_line = 1'b1;
  bit    mq[$];
  string tq[$];
  string cur_tag = "R7 idle";
  string scen = "";

  function automatic void build(input logic [8:0] d, input logic [2:0] sz,
                                input logic [1:0] pm, input logic st);
    int n;
    int ones;
    n = (sz == 3'd0) ? 5 : (sz == 3'd1) ? 6 : (sz == 3'd2) ? 7 : (sz == 3'd7) ? 9 : 8;
    mq.delete();
    tq.delete();
    mq.push_back(1'b0); tq.push_back("R2 start");
    ones = 0;
    for (int i = 0; i < n; i++) begin
      mq.push_back(d[i]); tq.push_back("R3 data");
      ones += int'(d[i]);
    end
    if (pm[1]) begin
      mq.push_back(pm[0] ? ((ones % 2) == 0) : ((ones % 2) == 1));
      tq.push_back("R4 parity");
    end
    mq.push_back(1'b1); tq.push_back("R5 stop");
    if (st) begin mq.push_back(1'b1); tq.push_back("R5 stop"); end
  endfunction

  // Behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      exp_busy = 1'b0; exp_line = 1'b1; mq.delete(); tq.delete(); cur_tag = "R7 idle";
    end else if (bit_tick) begin
      if ((!exp_busy || mq.size() == 0) && in_valid) begin
        build(in_data, cfg_size, cfg_par, cfg_stop2);
        exp_line = mq.pop_front(); cur_tag = tq.pop_front();
        exp_busy = 1'b1; accepted = 1;
      end else if (exp_busy) begin
        if (mq.size() > 0) begin
          exp_line = mq.pop_front(); cur_tag = tq.pop_front();
        end else begin
          exp_busy = 1'b0; exp_line = 1'b1; cur_tag = "R7 idle";
        end
      end
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL R1 watchdog: actual cycles=%0d expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s%s: actual=%0b expected=%0b at cycle %0d", scen, tag, act, expv, cycles);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    chk({cur_tag, " line"}, tx_line, exp_line);
    chk("R2 busy", busy, exp_busy);
    if (!bit_tick) chk("R6 hold", tx_line, prev_line);
    prev_line = tx_line;
    tick_cnt = (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
    bit_tick = (tick_cnt == 0);
    #1;
    chk("R1 ready", in_ready, bit_tick && (!exp_busy || mq.size() == 0));
  endtask

  task automatic send(input logic [8:0] d);
    in_data = d;
    in_valid = 1'b1;
    accepted = 0;
    while (accepted == 0) cycle();
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_busy) cycle();
    cycle();
  endtask

  int codes[5] = '{0, 1, 2, 3, 7};
  int pms[3]   = '{0, 2, 3};

  initial begin
    repeat (4) @(negedge clk);
    chk("R7 reset line", tx_line, 1'b1);
    chk("R7 reset busy", busy, 1'b0);
    rst_n = 1'b1;
    prev_line = 1'b1;
    cycle();

    // All thirty formats, tick period 1..4 (R3 R4 R5 R6)
    for (int si = 0; si < 5; si++)
      for (int pi = 0; pi < 3; pi++)
        for (int st = 0; st < 2; st++) begin
          cfg_size  = 3'(codes[si]);
          cfg_par   = 2'(pms[pi]);
          cfg_stop2 = st[0];
          tick_div  = 1 + ((si + pi + st) % 4);
          send(9'(9'h1A5 ^ (si * 37 + pi * 11 + st * 5)));
          wait_idle();
        end

    // Fallback codes: size 100/101/110 act as 8, parity 01 acts as none (R3 R4)
    scen = "R3 fallback ";
    tick_div = 2;
    for (int c = 4; c < 7; c++) begin
      cfg_size = 3'(c); cfg_par = 2'b01; cfg_stop2 = 1'b0;
      send(9'(9'h1F0 | c));
      wait_idle();
    end
    cfg_size = 3'b000; cfg_par = 2'b10;
    send(9'h1E3);
    wait_idle();

    // Back-to-back frames (R9)
    scen = "R9 ";
    tick_div = 3;
    cfg_size = 3'b011; cfg_par = 2'b11; cfg_stop2 = 1'b0;
    for (int k = 0; k < 5; k++) send(9'(k * 53 + 7));
    wait_idle();
    tick_div = 1;
    cfg_size = 3'b000; cfg_par = 2'b00;
    for (int k = 0; k < 4; k++) send(9'(k * 91 + 1));
    wait_idle();

    // Configuration changed mid-frame (R8)
    scen = "R8 ";
    tick_div = 4;
    cfg_size = 3'b111; cfg_par = 2'b11; cfg_stop2 = 1'b1;
    send(9'h155);
    cfg_size = 3'b000; cfg_par = 2'b00; cfg_stop2 = 1'b0;
    repeat (10) cycle();
    cfg_size = 3'b010; cfg_par = 2'b10;
    wait_idle();

    // Offer held while busy, data changing (R10)
    scen = "R10 ";
    tick_div = 3;
    cfg_size = 3'b011; cfg_par = 2'b10; cfg_stop2 = 1'b1;
    send(9'h0F0);
    in_valid = 1'b1;
    in_data = 9'h1FF;
    repeat (5) cycle();
    in_data = 9'h003;
    repeat (4) cycle();
    send(9'h12C);
    wait_idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule